// File: doc/BRIEF.md
# PWM Output Fault and Override Stage

This block sits between a PWM generator and the two output pins of one PWM unit, the high-side pin (H) and the low-side pin (L). It decides what each pin carries: the generator waveform, a fixed level chosen by software, or a safe level during a fault. Several fault sources enter the block, and each has its own enable. Any enabled source that is active blanks both pins at once, through combinational logic only, so there is no wait for a clock edge.

The fault is also captured in a sticky state bit that keeps the pins blanked after the source goes away. One configuration bit selects how that state is released. In automatic mode it clears at the next period-start pulse, provided no enabled fault is still active. In manual mode it clears only when software writes a clear pulse. Each pin also has an override enable and an override value that replace the generator waveform with a constant. A current-limit indication passes through the block with one register of delay, for use by a later stage.

Top module: `pwm_fault_ovr`

## Requirements
- R1: While reset is held and in the first cycle after it, with no enabled fault active, `pwm_h_out`, `pwm_l_out`, `fault_latched` and `cl_out` are all 0.
- R2: The fault condition is the OR over i of `fault_src[i] & fault_en[i]`. A source whose enable bit is 0 changes neither the pins nor `fault_latched`.
- R3: While the fault condition is true, `pwm_h_out` equals `safe_h` and `pwm_l_out` equals `safe_l` in the same cycle, with no clock edge between the fault input and the pins.
- R4: A fault condition seen at a clock edge sets `fault_latched` after that edge. While `fault_latched` is 1, the pins keep the safe levels even when the fault condition has gone.
- R5: In automatic mode (`auto_resume` = 1), `fault_latched` clears at an edge where `period_start` is 1 and the fault condition is false. In this mode `fault_clr` has no effect.
- R6: In manual mode (`auto_resume` = 0), `fault_latched` clears only at an edge where `fault_clr` is 1 and the fault condition is false. In this mode `period_start` has no effect.
- R7: Override bit 0 of `ovr_en`/`ovr_val` belongs to the H pin and bit 1 to the L pin. When a pin's enable bit is 1 at an edge and no fault blanks that pin, the pin shows the matching `ovr_val` bit from the next cycle onward.
- R8: With no fault and no override, each pin shows its raw generator input as it was at the previous clock edge, one register of delay.
- R9: A fault takes priority over an override, and an override takes priority over the generator waveform.
- R10: `cl_out` equals the value `cl_in` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_h_in | input | 1 | Raw high-side waveform from the generator |
| pwm_l_in | input | 1 | Raw low-side waveform from the generator |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| fault_src | input | NUM_FAULT | Fault source lines, active high |
| fault_en | input | NUM_FAULT | Per-source fault enable |
| auto_resume | input | 1 | 1: release at period start; 0: release by software clear |
| safe_h | input | 1 | Level of the H pin during a fault |
| safe_l | input | 1 | Level of the L pin during a fault |
| ovr_en | input | 2 | Override enable, bit 0 H, bit 1 L |
| ovr_val | input | 2 | Override level, bit 0 H, bit 1 L |
| fault_clr | input | 1 | Write-one-to-clear pulse for the captured fault |
| cl_in | input | 1 | Current-limit indication |
| pwm_h_out | output | 1 | High-side pin drive |
| pwm_l_out | output | 1 | Low-side pin drive |
| fault_latched | output | 1 | Captured fault state |
| cl_out | output | 1 | Current-limit indication delayed by one register |

## Verification
The assertions assume that the fault sources, enables and configuration bits change only between clock edges, so that the value seen at an edge is the one that sets or holds the captured fault. They also assume that `period_start` and `fault_clr` are one-cycle pulses. The stimulus drives every input just after a falling edge and holds it until the next falling edge. In one directed case a fault is raised and lowered between edges, to show that the pins react without a clock. Faults are kept rare in the random phase, so that release, override and normal pass-through all occur often.

// File: rtl/pwm_fo_pkg.sv
package pwm_fo_pkg;
  localparam int PIN_H  = 0;
  localparam int PIN_L  = 1;
  localparam int N_PINS = 2;

  typedef enum logic {
    RESUME_MANUAL = 1'b0,
    RESUME_AUTO   = 1'b1
  } resume_mode_e;
endpackage

// File: rtl/pwm_fo_combine.sv
module pwm_fo_combine #(
  parameter int NUM_FAULT = 4
) (
  input  logic [NUM_FAULT-1:0] src,
  input  logic [NUM_FAULT-1:0] en,
  output logic                 any
);
  logic [NUM_FAULT-1:0] gated;
  logic [NUM_FAULT:0]   chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_src
    assign gated[i]   = src[i] & en[i];
    assign chain[i+1] = chain[i] | gated[i];
  end
  assign any = chain[NUM_FAULT];
endmodule

// File: rtl/pwm_fo_latch.sv
module pwm_fo_latch
  import pwm_fo_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fault_now,
  input  resume_mode_e mode,
  input  logic         period_start,
  input  logic         sw_clr,
  output logic         held
);
  logic release_ev;

  always_comb begin
    case (mode)
      RESUME_AUTO:   release_ev = period_start;
      default:       release_ev = sw_clr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            held <= 1'b0;
    else if (fault_now) held <= 1'b1;
    else if (release_ev) held <= 1'b0;
  end

  // R4: a fault seen at an edge is captured
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    fault_now |=> held);
  // R6: manual mode holds until a software clear
  p_manual_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == RESUME_MANUAL && held && !sw_clr) |=> held);
  // R5: automatic mode holds between period starts
  p_auto_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == RESUME_AUTO && held && !period_start) |=> held);
endmodule

// File: rtl/pwm_fo_pin.sv
module pwm_fo_pin (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic blank,
  input  logic safe,
  output logic pin
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (ovr_en) sel_q <= ovr_val;
    else             sel_q <= raw;
  end

  assign pin = blank ? safe : sel_q;

  // R9: an override wins over the waveform once the register has taken it
  p_ovr_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr_en && !$past(rst)) |=> (blank || pin == $past(ovr_val)));
endmodule

// File: rtl/pwm_fault_ovr.sv
module pwm_fault_ovr
  import pwm_fo_pkg::*;
#(
  parameter int NUM_FAULT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwm_h_in,
  input  logic                 pwm_l_in,
  input  logic                 period_start,
  input  logic [NUM_FAULT-1:0] fault_src,
  input  logic [NUM_FAULT-1:0] fault_en,
  input  logic                 auto_resume,
  input  logic                 safe_h,
  input  logic                 safe_l,
  input  logic [1:0]           ovr_en,
  input  logic [1:0]           ovr_val,
  input  logic                 fault_clr,
  input  logic                 cl_in,
  output logic                 pwm_h_out,
  output logic                 pwm_l_out,
  output logic                 fault_latched,
  output logic                 cl_out
);
  logic              fault_now;
  logic              blank;
  resume_mode_e      mode;
  logic [N_PINS-1:0] raw_v, safe_v, pin_v;
  logic              cl_q;

  assign mode = resume_mode_e'(auto_resume);

  pwm_fo_combine #(.NUM_FAULT(NUM_FAULT)) u_comb (
    .src (fault_src),
    .en  (fault_en),
    .any (fault_now)
  );

  pwm_fo_latch u_latch (
    .clk          (clk),
    .rst          (rst),
    .fault_now    (fault_now),
    .mode         (mode),
    .period_start (period_start),
    .sw_clr       (fault_clr),
    .held         (fault_latched)
  );

  assign blank = fault_now | fault_latched;

  assign raw_v[PIN_H]  = pwm_h_in;
  assign raw_v[PIN_L]  = pwm_l_in;
  assign safe_v[PIN_H] = safe_h;
  assign safe_v[PIN_L] = safe_l;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    pwm_fo_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .raw     (raw_v[p]),
      .ovr_en  (ovr_en[p]),
      .ovr_val (ovr_val[p]),
      .blank   (blank),
      .safe    (safe_v[p]),
      .pin     (pin_v[p])
    );
  end

  assign pwm_h_out = pin_v[PIN_H];
  assign pwm_l_out = pin_v[PIN_L];

  always_ff @(posedge clk) begin
    if (rst) cl_q <= 1'b0;
    else     cl_q <= cl_in;
  end
  assign cl_out = cl_q;

  // R3: an enabled fault forces both pins to the safe levels
  p_safe_h_r3: assert property (@(posedge clk) disable iff (rst)
    (|(fault_src & fault_en)) |-> (pwm_h_out == safe_h));
  p_safe_l_r3: assert property (@(posedge clk) disable iff (rst)
    (|(fault_src & fault_en)) |-> (pwm_l_out == safe_l));
  // R4: a captured fault keeps the pins safe
  p_latched_safe_r4: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> (pwm_h_out == safe_h && pwm_l_out == safe_l));
  // R5: automatic release at a clean period start
  p_auto_release_r5: assert property (@(posedge clk) disable iff (rst)
    (auto_resume && fault_latched && period_start && !(|(fault_src & fault_en)))
    |=> !fault_latched);
  // R6: manual release by a clean software clear
  p_manual_release_r6: assert property (@(posedge clk) disable iff (rst)
    (!auto_resume && fault_latched && fault_clr && !(|(fault_src & fault_en)))
    |=> !fault_latched);
  // R10: current-limit pass-through delay
  p_cl_delay_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cl_out == $past(cl_in)));
endmodule

// File: tb/pwm_fault_ovr_tb_top.sv
module pwm_fault_ovr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic rst;
  logic pwm_h_in, pwm_l_in, period_start, auto_resume, safe_h, safe_l;
  logic fault_clr, cl_in;
  logic [NF-1:0] fault_src, fault_en;
  logic [1:0] ovr_en, ovr_val;
  logic pwm_h_out, pwm_l_out, fault_latched, cl_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  logic m_held, m_h, m_l, m_cl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_ovr #(.NUM_FAULT(NF)) dut_i (
    .clk(clk), .rst(rst), .pwm_h_in(pwm_h_in), .pwm_l_in(pwm_l_in),
    .period_start(period_start), .fault_src(fault_src), .fault_en(fault_en),
    .auto_resume(auto_resume), .safe_h(safe_h), .safe_l(safe_l),
    .ovr_en(ovr_en), .ovr_val(ovr_val), .fault_clr(fault_clr), .cl_in(cl_in),
    .pwm_h_out(pwm_h_out), .pwm_l_out(pwm_l_out),
    .fault_latched(fault_latched), .cl_out(cl_out)
  );

  function automatic logic f_fault(logic [NF-1:0] s, logic [NF-1:0] e);
    return |(s & e);
  endfunction

  function automatic logic f_pin(logic flt, logic held, logic safe, logic q);
    return (flt || held) ? safe : q;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // compare all outputs with the model for the inputs now applied
  task automatic check_all(string tag_pin, string tag_hold);
    logic f;
    f = f_fault(fault_src, fault_en);
    chk(tag_pin, pwm_h_out, f_pin(f, m_held, safe_h, m_h));
    chk(tag_pin, pwm_l_out, f_pin(f, m_held, safe_l, m_l));
    chk(tag_hold, fault_latched, m_held);
    chk("R10", cl_out, m_cl);
  endtask

  // advance one clock edge and update the model with the held inputs
  task automatic tick();
    logic f;
    @(posedge clk);
    f = f_fault(fault_src, fault_en);
    if (rst) begin
      m_held = 1'b0; m_h = 1'b0; m_l = 1'b0; m_cl = 1'b0;
    end else begin
      if (f) m_held = 1'b1;
      else if (auto_resume ? period_start : fault_clr) m_held = 1'b0;
      m_h  = ovr_en[0] ? ovr_val[0] : pwm_h_in;
      m_l  = ovr_en[1] ? ovr_val[1] : pwm_l_in;
      m_cl = cl_in;
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    pwm_h_in = 0; pwm_l_in = 0; period_start = 0; auto_resume = 1;
    safe_h = 0; safe_l = 0; fault_clr = 0; cl_in = 0;
    fault_src = '0; fault_en = '0; ovr_en = '0; ovr_val = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic f;
    string tp, th;
    void'($urandom(32'h5EED_0042));
    idle_inputs();
    m_held = 0; m_h = 0; m_l = 0; m_cl = 0;
    rst = 1;
    @(negedge clk);
    tick(); tick();
    #1 check_all("R1", "R1");
    rst = 0;
    tick();
    #1 check_all("R1", "R1");

    // R8: normal pass-through with one register of delay
    pwm_h_in = 1; pwm_l_in = 0; cl_in = 1;
    #1 check_all("R8", "R1");
    tick();
    #1 check_all("R8", "R1");
    chk("R8", pwm_h_out, 1'b1);
    chk("R10", cl_out, 1'b1);

    // R2: a disabled source has no effect
    fault_src = 4'b0100; fault_en = 4'b1011; safe_h = 0; safe_l = 1;
    #1 check_all("R2", "R2");
    chk("R2", pwm_h_out, 1'b1);
    tick();
    #1 chk("R2", fault_latched, 1'b0);

    // R3: a fault raised between edges blanks at once
    #1 fault_src = 4'b1000;
    #1 chk("R3", pwm_h_out, 1'b0);
    chk("R3", pwm_l_out, 1'b1);
    #1 fault_src = 4'b0000;
    #1 chk("R3", pwm_h_out, 1'b1);
    @(negedge clk);

    // R4 and R6: capture, manual hold, period start ignored
    auto_resume = 0; fault_src = 4'b0001;
    tick();
    fault_src = 0;
    #1 chk("R4", fault_latched, 1'b1);
    chk("R4", pwm_h_out, 1'b0);
    period_start = 1;
    tick();
    period_start = 0;
    #1 chk("R6", fault_latched, 1'b1);
    fault_clr = 1;
    tick();
    fault_clr = 0;
    #1 chk("R6", fault_latched, 1'b0);

    // R5: automatic mode, clear ignored, release at clean period start
    auto_resume = 1; fault_src = 4'b0010;
    tick();
    fault_src = 0; fault_clr = 1;
    tick();
    fault_clr = 0;
    #1 chk("R5", fault_latched, 1'b1);
    period_start = 1; fault_src = 4'b0010;
    tick();
    fault_src = 0;
    #1 chk("R5", fault_latched, 1'b1);
    tick();
    period_start = 0;
    #1 chk("R5", fault_latched, 1'b0);

    // R7 and R9: override per pin, fault beats override
    ovr_en = 2'b10; ovr_val = 2'b10; pwm_h_in = 0; pwm_l_in = 0;
    tick();
    #1 chk("R7", pwm_l_out, 1'b1);
    chk("R7", pwm_h_out, 1'b0);
    safe_l = 0; fault_src = 4'b0001;
    #1 chk("R9", pwm_l_out, 1'b0);
    fault_src = 0;
    tick();
    period_start = 1;
    tick();
    period_start = 0;
    #1 check_all("R9", "R5");
    idle_inputs();
    tick();

    // random phase
    for (int i = 0; i < N_RAND; i++) begin
      pwm_h_in     = 1'($urandom);
      pwm_l_in     = 1'($urandom);
      period_start = ($urandom % 6) == 0;
      fault_clr    = ($urandom % 6) == 0;
      cl_in        = 1'($urandom);
      ovr_en       = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      ovr_val      = 2'($urandom);
      fault_en     = NF'($urandom);
      fault_src    = (($urandom % 8) == 0) ? NF'($urandom) : '0;
      if (($urandom % 64) == 0) auto_resume = ~auto_resume;
      if (($urandom % 32) == 0) begin safe_h = 1'($urandom); safe_l = 1'($urandom); end
      #1;
      f = f_fault(fault_src, fault_en);
      tp = (f || m_held) ? "R3" : (ovr_en != 0 ? "R7" : "R8");
      th = f ? "R4" : (auto_resume ? "R5" : "R6");
      check_all(tp, th);
      tick();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule